// File: doc/BRIEF.md
# Power-Management Serial Bus Command Channel

This block is one firmware-facing command channel of a serial bus master used to reach power-management devices. Software sees five 32-bit words: a command word, a write-data word, a read-data word, a valid-clear word and a status word. Writing the command word starts one transaction. The channel presents it to a downstream serial engine over a request/acknowledge port, then waits for the acknowledge.

A write transaction returns the channel to idle as soon as it is acknowledged. A read transaction captures the returned bytes and parks in a "read data valid" state. It stays there until software writes 1 to the valid-clear word. That same write is also how software recovers a channel found parked in that state. A command written while the channel is busy is dropped and recorded in a sticky error bit.

Top module: `pmb_cmd_channel`

## Requirements
- R1: A synchronous active-high reset makes the status, read-data and write-data words read 0 and deasserts the downstream request.
- R2: The status word carries the channel state code in bits [3:1] and the sticky error in bit 0; all other bits read 0. Code 0 is idle, code 2 is request outstanding, and code 6 is read data valid.
- R3: A command-word write while idle raises the request on the next cycle. The request carries the command fields: type from bits [31:30], write flag from bit 29 (1 = write), slave ID from bits [27:24], byte count minus one from bits [18:16] and address from bits [15:0]. A count field of 4 to 7 is sent as four bytes (length code 3).
- R4: A write transaction sends the write-data word with every byte above the selected length forced to 0. On the acknowledge cycle the channel returns to idle.
- R5: On the acknowledge of a read, the read-data word takes the low bytes of the returned data selected by the length, with the upper bytes set to 0. The state becomes code 6.
- R6: The state stays at code 6 until a valid-clear write with bit 0 set. That write returns it to idle; a valid-clear write with bit 0 clear has no effect.
- R7: A command-word write while the state is not idle leaves the transaction in flight unchanged, starts nothing and sets the error bit.
- R8: A valid-clear write with bit 0 set clears the error bit in any state.
- R9: While the request is high and no acknowledge has arrived, the request and all its fields stay stable.
- R10: A write transaction leaves the read-data word unchanged.
- R11: The word offsets are 0 command, 1 write data, 2 read data, 3 valid-clear and 4 status. The write-data word reads back what was written, and offsets 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word offset |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value for reg_addr |
| dn_req | output | 1 | Transaction request to the serial engine |
| dn_write | output | 1 | 1 for a write, 0 for a read |
| dn_type | output | 2 | Command type code |
| dn_sid | output | 4 | Slave ID |
| dn_len_m1 | output | 2 | Byte count minus one |
| dn_addr | output | 16 | Register address on the slave |
| dn_wdata | output | 32 | Write bytes, upper unused bytes zero |
| dn_ack | input | 1 | One-cycle completion pulse from the engine |
| dn_rdata | input | 32 | Read bytes, valid with dn_ack |

## Verification
The acknowledge that ends a transaction can land in the same clock cycle as a software command write. That write is then seen against the old, busy state. The bench provokes this by raising dn_ack and a command-word write on the same cycle during an outstanding read. It then judges the result from the status word, which must show code 6 with the error bit set. It also checks that the read-data word holds the acknowledged bytes and that no new request appears on the following cycles.

// File: rtl/pmb_cmd_channel.sv
module pmb_cmd_channel #(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dn_req,
  output logic              dn_write,
  output logic [1:0]        dn_type,
  output logic [3:0]        dn_sid,
  output logic [1:0]        dn_len_m1,
  output logic [15:0]       dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic [31:0]       dn_rdata
);

  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_WD   = REG_AW'(1);
  localparam logic [REG_AW-1:0] A_RD   = REG_AW'(2);
  localparam logic [REG_AW-1:0] A_CLR  = REG_AW'(3);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(4);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_WACK = 3'd2;
  localparam logic [2:0] ST_VCLR = 3'd6;

  logic [2:0]  st;
  logic        err;
  logic [31:0] cmd_q, wdata_q, rdata_q, snd_q;
  logic [1:0]  len_q;

  wire we_cmd = reg_we && reg_addr == A_CMD;
  wire we_wd  = reg_we && reg_addr == A_WD;
  wire clr    = reg_we && reg_addr == A_CLR && reg_wdata[0];
  wire [1:0] new_len = reg_wdata[18] ? 2'd3 : reg_wdata[17:16];

  function automatic logic [31:0] keep_low(input logic [1:0] n, input logic [31:0] d);
    case (n)
      2'd0:    keep_low = {24'h0, d[7:0]};
      2'd1:    keep_low = {16'h0, d[15:0]};
      2'd2:    keep_low = {8'h0, d[23:0]};
      default: keep_low = d;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      err     <= 1'b0;
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      snd_q   <= '0;
      len_q   <= '0;
    end else begin
      if (we_wd) wdata_q <= reg_wdata;
      case (st)
        ST_IDLE: if (we_cmd) begin
          cmd_q <= reg_wdata;
          len_q <= new_len;
          snd_q <= keep_low(new_len, wdata_q);
          st    <= ST_WACK;
        end
        ST_WACK: if (dn_ack) begin
          if (cmd_q[29]) st <= ST_IDLE;
          else begin
            rdata_q <= keep_low(len_q, dn_rdata);
            st      <= ST_VCLR;
          end
        end
        ST_VCLR: if (clr) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
      if (we_cmd && st != ST_IDLE) err <= 1'b1;
      else if (clr)                err <= 1'b0;
    end
  end

  assign dn_req    = st == ST_WACK;
  assign dn_write  = cmd_q[29];
  assign dn_type   = cmd_q[31:30];
  assign dn_sid    = cmd_q[27:24];
  assign dn_len_m1 = len_q;
  assign dn_addr   = cmd_q[15:0];
  assign dn_wdata  = snd_q;

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_WD:    reg_rdata = wdata_q;
      A_RD:    reg_rdata = rdata_q;
      A_STAT:  reg_rdata = {28'h0, st, err};
      default: reg_rdata = '0;
    endcase
  end

endmodule

module pmb_cmd_channel_chk #(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        st,
  input logic              err,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              dn_req,
  input logic              dn_write,
  input logic [1:0]        dn_type,
  input logic [3:0]        dn_sid,
  input logic [1:0]        dn_len_m1,
  input logic [15:0]       dn_addr,
  input logic [31:0]       dn_wdata,
  input logic              dn_ack
);
  wire cmd_w = reg_we && reg_addr == REG_AW'(0);
  wire clr_w = reg_we && reg_addr == REG_AW'(3) && reg_wdata[0];

  always @(posedge clk)
    if (!rst) assert_code_legal_R2: assert (st == 3'd0 || st == 3'd2 || st == 3'd6);

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_sid) && $stable(dn_type)
                          && $stable(dn_len_m1) && $stable(dn_write) && $stable(dn_wdata));
  assert_write_done_R4: assert property (@(posedge clk) disable iff (rst)
    dn_req && dn_ack && dn_write |=> st == 3'd0);
  assert_read_done_R5: assert property (@(posedge clk) disable iff (rst)
    dn_req && dn_ack && !dn_write |=> st == 3'd6);
  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (rst)
    st == 3'd6 && !clr_w |=> st == 3'd6);
  assert_reject_busy_R7: assert property (@(posedge clk) disable iff (rst)
    st != 3'd0 && cmd_w |=> err && $stable(dn_addr) && $stable(dn_sid));
  assert_clear_err_R8: assert property (@(posedge clk) disable iff (rst)
    clr_w |=> !err);
endmodule

bind pmb_cmd_channel pmb_cmd_channel_chk #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst(rst), .st(st), .err(err), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dn_req(dn_req), .dn_write(dn_write), .dn_type(dn_type),
  .dn_sid(dn_sid), .dn_len_m1(dn_len_m1), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
  .dn_ack(dn_ack)
);

// File: tb/pmb_cmd_channel_tb.sv
module pmb_cmd_channel_tb_top;
  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic dn_req, dn_write, dn_ack = 0;
  logic [1:0] dn_type, dn_len_m1;
  logic [3:0] dn_sid;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pmb_cmd_channel #(.REG_AW(3)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dn_req(dn_req), .dn_write(dn_write), .dn_type(dn_type),
    .dn_sid(dn_sid), .dn_len_m1(dn_len_m1), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ack(input logic [31:0] d);
    @(negedge clk); dn_ack = 1; dn_rdata = d;
    @(negedge clk); dn_ack = 0;
  endtask

  function automatic logic [31:0] cmdw(input logic [1:0] t, input logic w, input logic [3:0] s,
                                       input logic [2:0] l, input logic [15:0] a);
    return {t, w, 1'b0, s, 5'b0, l, a};
  endfunction

  function automatic logic [31:0] low(input int n, input logic [31:0] d);
    logic [63:0] m = (64'd1 << (8 * n)) - 1;
    return d & m[31:0];
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd4, v); check("R1 status", v, 0);
    rd(3'd2, v); check("R1 rdata", v, 0);
    rd(3'd1, v); check("R1 wdata", v, 0);
    check("R1 req", {31'b0, dn_req}, 0);
    rd(3'd6, v); check("R11 unused", v, 0);
  endtask

  task automatic t_write(input logic [1:0] t, input logic [3:0] s, input logic [2:0] l,
                         input logic [15:0] a, input logic [31:0] d);
    logic [31:0] v;
    int n = (l > 3) ? 4 : l + 1;
    wr(3'd1, d);
    rd(3'd1, v); check("R11 wdata readback", v, d);
    wr(3'd0, cmdw(t, 1'b1, s, l, a));
    check("R3 req", {31'b0, dn_req}, 1);
    check("R3 fields", {dn_type, dn_write, dn_sid, dn_len_m1, dn_addr},
          {t, 1'b1, s, 2'(n - 1), a});
    check("R4 masked wdata", dn_wdata, low(n, d));
    rd(3'd4, v); check("R2 busy code", v, 32'h4);
    repeat (2) @(negedge clk);
    check("R9 held", {dn_req, dn_addr, dn_sid}, {1'b1, a, s});
    ack(32'hFFFF_FFFF);
    rd(3'd4, v); check("R4 idle after write", v, 0);
    check("R4 req drop", {31'b0, dn_req}, 0);
  endtask

  task automatic t_read(input logic [2:0] l, input logic [31:0] d);
    logic [31:0] v;
    int n = l + 1;
    wr(3'd0, cmdw(2'd1, 1'b0, 4'h9, l, 16'h0123));
    check("R3 read dir", {31'b0, dn_write}, 0);
    ack(d);
    rd(3'd4, v); check("R5 valid code", v, 32'hC);
    rd(3'd2, v); check("R5 rdata", v, low(n, d));
    wr(3'd3, 32'h0);
    rd(3'd4, v); check("R6 clear bit0=0 ignored", v, 32'hC);
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R6 holds", v, 32'hC);
    wr(3'd3, 32'h1);
    rd(3'd4, v); check("R6 cleared to idle", v, 0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    wr(3'd1, 32'h1234_5678);
    wr(3'd0, cmdw(2'd0, 1'b1, 4'h3, 3'd1, 16'hAAAA));
    wr(3'd0, cmdw(2'd2, 1'b0, 4'h7, 3'd0, 16'h5555));
    check("R7 fields kept", {dn_addr, dn_sid, dn_write}, {16'hAAAA, 4'h3, 1'b1});
    rd(3'd4, v); check("R7 err set", v, 32'h5);
    ack(0);
    rd(3'd4, v); check("R7 idle keeps err", v, 32'h1);
    @(negedge clk);
    check("R7 no new req", {31'b0, dn_req}, 0);
    wr(3'd3, 32'h1);
    rd(3'd4, v); check("R8 err cleared", v, 0);
  endtask

  task automatic t_keep;
    logic [31:0] v;
    t_read(3'd3, 32'hCAFE_F00D);
    t_write(2'd1, 4'h2, 3'd3, 16'h0042, 32'h0BAD_0BAD);
    rd(3'd2, v); check("R10 rdata kept", v, 32'hCAFE_F00D);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(3'd0, cmdw(2'd3, 1'b0, 4'hF, 3'd1, 16'hBEEF));
    @(negedge clk);
    dn_ack = 1; dn_rdata = 32'h8765_4321;
    reg_we = 1; reg_addr = 0; reg_wdata = cmdw(2'd1, 1'b1, 4'h1, 3'd0, 16'h0001);
    @(negedge clk); dn_ack = 0; reg_we = 0;
    rd(3'd4, v); check("R7 collide status", v, 32'hD);
    rd(3'd2, v); check("R5 collide rdata", v, 32'h0000_4321);
    repeat (2) @(negedge clk);
    check("R7 collide no req", {31'b0, dn_req}, 0);
    wr(3'd3, 32'h1);
    rd(3'd4, v); check("R6 R8 recover", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_write(2'd0, 4'h5, 3'd0, 16'h1000, 32'hA1B2_C3D4);
    t_write(2'd3, 4'hE, 3'd2, 16'hFFFF, 32'h0102_0304);
    t_write(2'd2, 4'h0, 3'd6, 16'h0080, 32'hDEAD_BEEF);
    t_read(3'd0, 32'h1122_3344);
    t_read(3'd1, 32'h5566_7788);
    t_busy;
    t_keep;
    t_collide;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule